// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block turns block-level read and write requests into the byte frames that a serial EEPROM expects on an SPI link. A request gives a 16-bit start address, a byte count and a direction. The sequencer cuts the request into pieces of at most `CHUNK_MAX` bytes. It sends the command frames for each piece and moves the address on by the size of that piece. Write data is pulled from a byte stream and read data is pushed into a byte stream, both in ascending address order.

For each write piece, the sequencer first sends a one-byte enable frame. It then sends the program frame, which holds the opcode, the address and the data. After that it keeps sending status frames, with a programmable gap between them, until the device reports that it is no longer busy or the attempt limit is reached. For each read piece, it sends the read opcode, the address and one dummy byte per data byte. It drops the first three bytes that come back and forwards the rest. The serial shifter sits outside this block. It takes one byte at a time with a flag that marks the last byte of a frame, and it returns one received byte for each byte it sends.

Top module: `eeprom_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `busy`, `done`, `frm_tx_valid` and `rd_valid` are 0.
- R2: A request of length zero raises `done` in the cycle after it is accepted. It sends no frame byte and moves no data.
- R3: A write piece sends the frame {0x06} on its own (last set). It then sends {0x02, address[15:8], address[7:0], data...}, with last set only on the final data byte. The data bytes are taken from the write stream in order.
- R4: After a program frame, status frames {0x05, 0x00} (last on the second byte) are sent. Polling stops at the first frame whose second received byte has bit 0 clear. The other received bits are ignored.
- R5: Between the end of one status frame and the start of the next, at least `POLL_GAP` clock cycles pass with no frame byte offered.
- R6: If `POLL_MAX` status frames in a row all report busy, polling stops and `timeout_err` is set. The request still runs to completion, and `timeout_err` stays set until the next request is accepted.
- R7: A read piece of n bytes sends {0x03, address[15:8], address[7:0]} followed by n bytes of 0x00, with last on the final byte. The first three received bytes are dropped. Received bytes 3 onward come out on `rd_data` in order.
- R8: Each piece is at most `CHUNK_MAX` bytes (16 by default). The address of each piece is the previous piece's address plus its length, modulo 2^16.
- R9: A request is accepted only while the block is idle. Requests offered while it is busy are ignored and have no effect on the frames sent.
- R10: Once `frm_tx_valid` is high, the byte and its last flag stay stable until `frm_tx_ready`. Only one byte is in flight at a time: the next byte waits for the received byte of the previous one.
- R11: Once `rd_valid` is high, `rd_data` stays stable until `rd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Start address |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Status polling exhausted during the last request |
| wr_valid | input | 1 | Write byte available |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte taken |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Read byte taken |
| frm_tx_valid | output | 1 | Frame byte offered to the shifter |
| frm_tx_byte | output | 8 | Frame byte |
| frm_tx_last | output | 1 | Byte ends the frame |
| frm_tx_ready | input | 1 | Shifter takes the byte |
| frm_rx_valid | input | 1 | Received byte strobe |
| frm_rx_byte | input | 8 | Received byte |

## Verification
The assertions assume that the shifter returns exactly one received byte after each byte it accepts, and never returns one unasked. They also assume that the consumer of `rd_data` eventually raises `rd_ready`. The bench models the shifter so that it answers one cycle after each accepted byte and never otherwise. It throttles `frm_tx_ready`, `wr_valid` and `rd_ready` with fixed periodic patterns that always release within a few cycles. Status answers have bits 7..1 set, so a design that reads the wrong bit is caught. The dropped read bytes carry a distinct filler value, so a byte that leaks through shows up in the read data.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  localparam int ADDR_W = 16;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PROG = 8'h02;

  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_LOAD, S_TX, S_RX, S_PUSH, S_GAP, S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    F_WREN, F_PROG, F_STAT, F_READ
  } frame_kind_t;
endpackage

// File: rtl/eeprom_seq_chunker.sv
module eeprom_seq_chunker #(
  parameter int LEN_W     = 16,
  parameter int CHUNK_MAX = 16,
  localparam int CNT_W    = $clog2(CHUNK_MAX + 1)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              load,
  input  logic [eeprom_seq_pkg::ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]                  load_len,
  input  logic                              advance,
  output logic [eeprom_seq_pkg::ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]                  piece_len,
  output logic                              final_piece
);
  logic [LEN_W-1:0] remain;

  always_comb begin
    if (remain > LEN_W'(CHUNK_MAX)) piece_len = CNT_W'(CHUNK_MAX);
    else                            piece_len = remain[CNT_W-1:0];
  end

  assign final_piece = (remain <= LEN_W'(CHUNK_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      remain   <= load_len;
    end else if (advance) begin
      cur_addr <= cur_addr + eeprom_seq_pkg::ADDR_W'(piece_len);
      remain   <= remain - LEN_W'(piece_len);
    end
  end
endmodule

// File: rtl/eeprom_seq_poll.sv
module eeprom_seq_poll #(
  parameter int POLL_GAP = 40000,
  parameter int POLL_MAX = 1000,
  localparam int GW      = $clog2(POLL_GAP + 1),
  localparam int TW      = $clog2(POLL_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic miss,
  output logic gap_over,
  output logic exhausted
);
  logic [GW-1:0] gap_cnt;
  logic [TW-1:0] tries;

  assign gap_over  = (gap_cnt == '0);
  assign exhausted = (tries == TW'(POLL_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
      tries   <= '0;
    end else begin
      if (miss)               gap_cnt <= GW'(POLL_GAP - 1);
      else if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
      if (restart)            tries <= '0;
      else if (miss)          tries <= tries + 1'b1;
    end
  end
endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq #(
  parameter int LEN_W     = 16,
  parameter int CHUNK_MAX = 16,
  parameter int POLL_GAP  = 40000,
  parameter int POLL_MAX  = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             timeout_err,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             rd_ready,
  output logic             frm_tx_valid,
  output logic [7:0]       frm_tx_byte,
  output logic             frm_tx_last,
  input  logic             frm_tx_ready,
  input  logic             frm_rx_valid,
  input  logic [7:0]       frm_rx_byte
);
  import eeprom_seq_pkg::*;

  localparam int CNT_W = $clog2(CHUNK_MAX + 1);
  localparam int IDX_W = $clog2(CHUNK_MAX + 4);

  seq_state_t         st;
  frame_kind_t        fk;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   flen;
  logic [7:0]         tx_q, rd_q, nxt_byte;
  logic               last_q, wr_mode, err_q;
  logic [ADDR_W-1:0]  cur_addr;
  logic [CNT_W-1:0]   piece_len;
  logic               final_piece, gap_over, exhausted;
  logic               accept, need_data, rx_end, stat_idle, stat_busy, adv, restart, miss;

  eeprom_seq_chunker #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX)) chunk_i (
    .clk(clk), .rst(rst), .load(accept), .load_addr(req_addr), .load_len(req_len),
    .advance(adv), .cur_addr(cur_addr), .piece_len(piece_len), .final_piece(final_piece)
  );

  eeprom_seq_poll #(.POLL_GAP(POLL_GAP), .POLL_MAX(POLL_MAX)) poll_i (
    .clk(clk), .rst(rst), .restart(restart), .miss(miss),
    .gap_over(gap_over), .exhausted(exhausted)
  );

  always_comb begin
    case (fk)
      F_WREN:  flen = IDX_W'(1);
      F_STAT:  flen = IDX_W'(2);
      default: flen = IDX_W'(3) + IDX_W'(piece_len);
    endcase
  end

  assign need_data = (fk == F_PROG) && (idx >= IDX_W'(3));

  always_comb begin
    nxt_byte = 8'h00;
    case (fk)
      F_WREN: nxt_byte = OP_WREN;
      F_STAT: nxt_byte = (idx == '0) ? OP_STAT : 8'h00;
      default: begin
        if (idx == IDX_W'(0))      nxt_byte = (fk == F_PROG) ? OP_PROG : OP_READ;
        else if (idx == IDX_W'(1)) nxt_byte = cur_addr[15:8];
        else if (idx == IDX_W'(2)) nxt_byte = cur_addr[7:0];
        else if (fk == F_PROG)     nxt_byte = wr_data;
        else                       nxt_byte = 8'h00;
      end
    endcase
  end

  assign accept    = (st == S_IDLE) && req_valid;
  assign rx_end    = (st == S_RX) && frm_rx_valid && last_q && (fk != F_READ);
  assign stat_idle = rx_end && (fk == F_STAT) && !frm_rx_byte[0];
  assign stat_busy = rx_end && (fk == F_STAT) && frm_rx_byte[0];
  assign miss      = stat_busy && !exhausted;
  assign restart   = rx_end && (fk == F_PROG);
  assign adv       = stat_idle || (stat_busy && exhausted) ||
                     ((st == S_PUSH) && rd_ready && last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      fk      <= F_WREN;
      idx     <= '0;
      tx_q    <= '0;
      rd_q    <= '0;
      last_q  <= 1'b0;
      wr_mode <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (adv) st <= final_piece ? S_DONE : S_PLAN;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_mode <= req_write;
          err_q   <= 1'b0;
          st      <= (req_len == '0) ? S_DONE : S_PLAN;
        end
        S_PLAN: begin
          fk  <= wr_mode ? F_WREN : F_READ;
          idx <= '0;
          st  <= S_LOAD;
        end
        S_LOAD: if (!need_data || wr_valid) begin
          tx_q   <= nxt_byte;
          last_q <= (idx == flen - 1'b1);
          st     <= S_TX;
        end
        S_TX: if (frm_tx_ready) st <= S_RX;
        S_RX: if (frm_rx_valid) begin
          if (fk == F_READ && idx >= IDX_W'(3)) begin
            rd_q <= frm_rx_byte;
            st   <= S_PUSH;
          end else if (!last_q) begin
            idx <= idx + 1'b1;
            st  <= S_LOAD;
          end else if (fk == F_WREN) begin
            fk  <= F_PROG;
            idx <= '0;
            st  <= S_LOAD;
          end else if (fk == F_PROG) begin
            fk  <= F_STAT;
            idx <= '0;
            st  <= S_LOAD;
          end else if (stat_busy && exhausted) begin
            err_q <= 1'b1;
          end else if (miss) begin
            idx <= '0;
            st  <= S_GAP;
          end
        end
        S_PUSH: if (rd_ready && !last_q) begin
          idx <= idx + 1'b1;
          st  <= S_LOAD;
        end
        S_GAP:  if (gap_over) st <= S_LOAD;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == S_IDLE);
  assign busy         = (st != S_IDLE);
  assign done         = (st == S_DONE);
  assign timeout_err  = err_q;
  assign wr_ready     = (st == S_LOAD) && need_data;
  assign rd_valid     = (st == S_PUSH);
  assign rd_data      = rd_q;
  assign frm_tx_valid = (st == S_TX);
  assign frm_tx_byte  = tx_q;
  assign frm_tx_last  = last_q;
endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       frm_tx_valid,
  input logic       frm_tx_ready,
  input logic [7:0] frm_tx_byte,
  input logic       frm_tx_last,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (frm_tx_valid && !frm_tx_ready) |=> (frm_tx_valid && $stable(frm_tx_byte) && $stable(frm_tx_last)));

  a_r10_single_flight: assert property (@(posedge clk) disable iff (rst)
    (frm_tx_valid && frm_tx_ready) |=> !frm_tx_valid);

  a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  a_r2_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!frm_tx_valid && !rd_valid));

  a_r9_start_on_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));
endmodule

bind eeprom_seq eeprom_seq_chk chk_i (.*);

// File: tb/eeprom_seq_tb_top.sv
`timescale 1ns/1ps
module eeprom_seq_tb_top;
  localparam int GAP = 6;
  localparam int LIM = 5;
  localparam int CH  = 16;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic req_valid = 0, req_ready, req_write = 0, busy, done, timeout_err;
  logic [15:0] req_addr = 0;
  logic [15:0] req_len = 0;
  logic wr_valid = 0, wr_ready, rd_valid, rd_ready = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic frm_tx_valid, frm_tx_last, frm_tx_ready = 0, frm_rx_valid = 0;
  logic [7:0] frm_tx_byte, frm_rx_byte = 0;

  eeprom_seq #(.LEN_W(16), .CHUNK_MAX(CH), .POLL_GAP(GAP), .POLL_MAX(LIM)) dut_i (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  // shifter / stream model state
  logic [7:0] lb [512]; bit ll [512]; int ls [512]; int ln = 0;
  logic [7:0] rbuf [256]; int rcnt = 0;
  int wcnt = 0; bit wpend = 0; bit tpend = 0; logic [7:0] resp = 0;
  int fpos = 0; logic [7:0] fop = 0, fahi = 0, falo = 0;
  int bz_cfg = 0, busy_left = 0;

  // expected
  logic [7:0] eb [512]; bit el [512]; int en;
  logic [7:0] rexp [256]; int rexp_n; bit exp_err;

  function automatic logic [7:0] wpat(input int k); return 8'hA0 + 8'(k * 7); endfunction
  function automatic logic [7:0] rpat(input logic [15:0] a); return a[7:0] ^ a[15:8] ^ 8'h3C; endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      frm_rx_valid = 0; tpend = 0; wpend = 0;
    end else begin
      frm_tx_ready = (cyc % 4) != 3;
      rd_ready     = (cyc % 5) != 0;
      if (wpend) wcnt++;
      wr_valid = (cyc % 3) != 0;
      wr_data  = wpat(wcnt);
      wpend    = wr_valid && wr_ready;
      frm_rx_valid = tpend;
      frm_rx_byte  = resp;
      tpend = 0;
      if (rd_valid && rd_ready) begin rbuf[rcnt] = rd_data; rcnt++; end
      if (frm_tx_valid && frm_tx_ready) begin
        lb[ln] = frm_tx_byte; ll[ln] = frm_tx_last; ls[ln] = cyc; ln++;
        if (fpos == 0) fop = frm_tx_byte;
        if (fpos == 1) fahi = frm_tx_byte;
        if (fpos == 2) falo = frm_tx_byte;
        if (fpos == 0 && frm_tx_byte == 8'h02) busy_left = bz_cfg;
        if (fop == 8'h05 && fpos == 1) begin
          resp = (busy_left > 0) ? 8'hFF : 8'hFE;
          if (busy_left > 0) busy_left--;
        end else if (fop == 8'h03 && fpos >= 3)
          resp = rpat({fahi, falo} + 16'(fpos - 3));
        else resp = 8'hC3;
        fpos = frm_tx_last ? 0 : fpos + 1;
        tpend = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic push_e(input logic [7:0] b, input bit l);
    eb[en] = b; el[en] = l; en++;
  endtask

  task automatic build_exp(input bit w, input logic [15:0] a, input int len, input int bz);
    int rem = len, k = 0, n, p;
    logic [15:0] ca = a;
    en = 0; rexp_n = 0; exp_err = 0;
    while (rem > 0) begin
      n = (rem > CH) ? CH : rem;
      if (w) begin
        push_e(8'h06, 1); push_e(8'h02, 0); push_e(ca[15:8], 0); push_e(ca[7:0], 0);
        for (int j = 0; j < n; j++) push_e(wpat(k + j), j == n - 1);
        p = (bz >= LIM) ? LIM : bz + 1;
        if (bz >= LIM) exp_err = 1;
        for (int j = 0; j < p; j++) begin push_e(8'h05, 0); push_e(8'h00, 1); end
      end else begin
        push_e(8'h03, 0); push_e(ca[15:8], 0); push_e(ca[7:0], 0);
        for (int j = 0; j < n; j++) begin
          push_e(8'h00, j == n - 1);
          rexp[rexp_n] = rpat(ca + 16'(j)); rexp_n++;
        end
      end
      k += n; ca += 16'(n); rem -= n;
    end
  endtask

  task automatic start_req(input bit w, input logic [15:0] a, input int len, input int bz);
    @(negedge clk); #1;
    ln = 0; rcnt = 0; wcnt = 0; bz_cfg = bz;
    req_write = w; req_addr = a; req_len = 16'(len); req_valid = 1;
    @(negedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); #1; t++; end
    chk(t < 20000, "R9 completion", t, 0);
  endtask

  task automatic compare(input string tag);
    int bad = -1;
    chk(ln == en, {tag, " frame length"}, ln, en);
    for (int i = 0; i < en && i < ln; i++)
      if (bad < 0 && (lb[i] !== eb[i] || ll[i] !== el[i])) bad = i;
    chk(bad < 0, {tag, " frame bytes"}, (bad < 0) ? 0 : {lb[bad], 7'b0, ll[bad]},
        (bad < 0) ? 0 : {eb[bad], 7'b0, el[bad]});
    bad = -1;
    chk(rcnt == rexp_n, "R7 R11 read count", rcnt, rexp_n);
    for (int i = 0; i < rexp_n && i < rcnt; i++)
      if (bad < 0 && rbuf[i] !== rexp[i]) bad = i;
    chk(bad < 0, "R7 R11 read data", (bad < 0) ? 0 : rbuf[bad], (bad < 0) ? 0 : rexp[bad]);
    chk(timeout_err == exp_err, "R6 timeout flag", timeout_err, exp_err);
  endtask

  task automatic check_gaps();
    int prev_start = -1, start = 0, ok = 1, worst = 0;
    for (int i = 0; i < ln; i++) begin
      if (i == 0 || ll[i-1]) begin
        if (lb[i] == 8'h05 && prev_start >= 0 && lb[prev_start] == 8'h05)
          if (ls[i] - ls[i-1] < GAP + 1) begin ok = 0; worst = ls[i] - ls[i-1]; end
        prev_start = i;
      end
      start = i;
    end
    chk(ok == 1 && start >= 0, "R5 poll gap", worst, GAP + 1);
  endtask

  // {write, addr, len, busy polls}
  localparam logic [39:0] VEC [6] = '{
    {8'd1, 16'h0100, 8'd5,  8'd0},
    {8'd0, 16'h0200, 8'd4,  8'd0},
    {8'd1, 16'h12F8, 8'd20, 8'd2},
    {8'd0, 16'hFFF8, 8'd18, 8'd0},
    {8'd1, 16'h0040, 8'd16, 8'd1},
    {8'd0, 16'h0300, 8'd33, 8'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    // R1 reset state
    chk(req_ready && !busy && !done && !frm_tx_valid && !rd_valid, "R1 reset state",
        {req_ready, busy, done, frm_tx_valid, rd_valid}, 5'b10000);

    // R3 R4 R7 R8 table walk
    for (int v = 0; v < 6; v++) begin
      build_exp(VEC[v][32], VEC[v][31:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));
      start_req(VEC[v][32], VEC[v][31:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));
      wait_done();
      compare(VEC[v][32] ? "R3 R4 R8 R10 write" : "R7 R8 R10 read");
      if (VEC[v][32]) check_gaps();
    end

    // R2 zero length
    start_req(1'b1, 16'h0010, 0, 0);
    chk(done == 1'b1, "R2 zero-length done", done, 1);
    chk(ln == 0 && wcnt == 0, "R2 no traffic", ln, 0);
    @(negedge clk); #1;

    // R6 timeout then completion
    build_exp(1'b1, 16'h0500, 3, 9);
    start_req(1'b1, 16'h0500, 3, 9);
    wait_done();
    compare("R6 R4 timeout write");
    check_gaps();
    @(negedge clk); #1;
    chk(timeout_err == 1'b1, "R6 flag held", timeout_err, 1);
    build_exp(1'b0, 16'h0600, 2, 0);
    start_req(1'b0, 16'h0600, 2, 0);
    chk(timeout_err == 1'b0, "R6 flag cleared on accept", timeout_err, 0);
    wait_done();
    compare("R6 R7 after timeout");

    // R9 request while busy is ignored
    build_exp(1'b1, 16'h0700, 2, 1);
    start_req(1'b1, 16'h0700, 2, 1);
    begin
      int rdy_seen = 0;
      req_write = 0; req_addr = 16'h0A00; req_len = 16'd5; req_valid = 1;
      for (int i = 0; i < 10; i++) begin @(negedge clk); #1; if (req_ready) rdy_seen++; end
      req_valid = 0;
      chk(rdy_seen == 0, "R9 ready low while busy", rdy_seen, 0);
    end
    wait_done();
    compare("R9 R3 busy request ignored");
    @(negedge clk); #1;
    chk(req_ready == 1'b1 && busy == 1'b0, "R9 idle again", req_ready, 1);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule